// File: doc/BRIEF.md
# Linear11 Turn-On Delay Controller

This block stores the power-up delay setting of a supply rail and times the wait between a start request and the moment the output ramp may begin. Software reaches the setting through word writes and word reads at one fixed command code. The value travels in the signed-exponent, signed-mantissa LINEAR11 word. The block always keeps the setting as a count of 0.5 ms steps, with the exponent fixed at -1.

A write is checked before it is stored. A write is accepted only when it names an exact whole number of 0.5 ms steps from 0 to 255. If it does not, the write is dropped and an error pulse is raised. A separate restore strobe reloads the setting from backup storage. It does not reject the word; it rounds it to the nearest step and clamps it into range.

After the start input rises, a countdown of 0.5 ms timebase ticks runs. A short minimum-initialisation timer, counted in clock cycles, runs alongside it. The ramp enable output rises only when both have finished. It stays high while start is held. Dropping start at any point aborts or ends the sequence.

Top module: `ton_delay_ctrl`

## Requirements
- R1: Writes and reads act only when `cmd_i` equals `CMD_CODE` (default 8'h60); strobes at any other code change neither the stored setting, `err_o` nor `rd_valid_o`.
- R2: A read strobe at the command code gives `rd_valid_o` high for one cycle on the next clock, with `rdata_o` = {5'b11111, 3'b000, setting[7:0]}; bits 15:11 are the exponent, bits 10:0 the mantissa.
- R3: A written word, exponent in bits 15:11 and mantissa in bits 10:0 (both two's complement), is accepted when mantissa·2^exponent equals k·0.5 ms for an integer k in 0..255; k is stored.
- R4: A written word that fails R3 (negative, not on the 0.5 ms grid, or above 127.5 ms) raises `err_o` for exactly one cycle on the next clock and leaves the stored setting unchanged.
- R5: `restore_i` loads `restore_data_i` rounded to the nearest 0.5 ms step (half rounds up), clamped to 0..255; it never raises `err_o`, and it wins over a write in the same cycle.
- R6: After reset the setting reads back as exponent 11111b with mantissa `DEF_HALF_MS`, and `ramp_en_o`, `err_o`, `rd_valid_o` are low.
- R7: With the setting at k>0 and start held, `ramp_en_o` stays low until the k-th `tick_i` since start has been taken, and rises on the clock after it once the minimum timer has also expired.
- R8: Even with a setting of 0, `ramp_en_o` rises no earlier than `MIN_CYC`+1 clocks after the clock that first samples `start_i` high, and exactly then when the setting is 0.
- R9: Dropping `start_i` aborts a running countdown (ramp never asserts) or drops `ramp_en_o` on the next clock; a later start reloads the full setting.
- R10: Writes are taken at any time; a countdown already running keeps the value loaded at its start, and the new value applies from the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 8 | Command code of the current transaction |
| wr_en_i | input | 1 | Word write strobe |
| wdata_i | input | 16 | Write word, LINEAR11 |
| rd_en_i | input | 1 | Word read strobe |
| rdata_o | output | 16 | Read word, LINEAR11 with exponent -1 |
| rd_valid_o | output | 1 | Read data valid, one cycle |
| err_o | output | 1 | Invalid-data pulse for a rejected write |
| restore_i | input | 1 | Reload strobe from backup storage |
| restore_data_i | input | 16 | Backup word to load, LINEAR11 |
| tick_i | input | 1 | 0.5 ms timebase enable |
| start_i | input | 1 | Start condition, level |
| ramp_en_o | output | 1 | Output ramp may begin |

## Verification
The bench aims at exponent handling. It uses words with exponent 0 and -2, an off-grid -2 word, and values just inside and just over 127.5 ms. A decoder that ignored the exponent or truncated instead of rejecting would store the wrong step count or miss the error pulse. Restore words cover round-half-up, overflow clamping and negative clamping; truncation or wrap-around shows up in the read-back. On the timer side, a zero setting must still wait the minimum clock count. An abort followed by a restart must need the full tick count again. A write made during a countdown must not shorten it. A design that reset the minimum timer wrongly, resumed a partial count, or read the live register would raise the ramp early.

// File: rtl/ton_pkg.sv
package ton_pkg;
  localparam int HALF_W   = 8;
  localparam int HALF_MAX = (1 << HALF_W) - 1;

  typedef struct packed {
    logic              ok;
    logic [HALF_W-1:0] half;
  } lin_res_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RAMP} ton_st_e;
endpackage

// File: rtl/ton_lin11_norm.sv
// LINEAR11 word -> count of 0.5 ms steps. ROUND=0: exact check, ROUND=1: round+clamp.
module ton_lin11_norm
  import ton_pkg::*;
#(
  parameter bit ROUND = 1'b0
) (
  input  logic [15:0] word_i,
  output lin_res_t    res_o
);
  logic signed [31:0] man, val, bias, mask;
  logic signed [5:0]  sh, nsh;
  logic [4:0]         rsh;
  logic               exact;

  always_comb begin
    man  = {{21{word_i[10]}}, word_i[10:0]};
    sh   = $signed({word_i[15], word_i[15:11]}) + 6'sd1;  // scale to 0.5 ms units
    nsh  = -sh;
    rsh  = nsh[4:0];
    mask = '0;
    bias = '0;
    if (!sh[5]) begin
      val   = man <<< sh[4:0];
      exact = 1'b1;
    end else begin
      mask  = (32'sd1 <<< rsh) - 32'sd1;
      exact = ((man & mask) == 32'sd0);
      if (ROUND) bias = 32'sd1 <<< (rsh - 5'd1);
      val   = (man + bias) >>> rsh;
    end

    if (ROUND) begin
      res_o.ok = 1'b1;
      if (val[31])                      res_o.half = '0;
      else if (val > 32'(HALF_MAX))     res_o.half = HALF_W'(HALF_MAX);
      else                              res_o.half = val[HALF_W-1:0];
    end else begin
      res_o.ok   = exact && !val[31] && (val <= 32'(HALF_MAX));
      res_o.half = val[HALF_W-1:0];
    end
  end
endmodule

// File: rtl/ton_delay_reg.sv
module ton_delay_reg
  import ton_pkg::*;
#(
  parameter logic [HALF_W-1:0] DEF_HALF_MS = 8'd10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_hit_i,
  input  lin_res_t          wr_res_i,
  input  logic              rs_hit_i,
  input  lin_res_t          rs_res_i,
  input  logic              rd_hit_i,
  output logic [HALF_W-1:0] half_o,
  output logic [15:0]       rdata_o,
  output logic              rd_valid_o,
  output logic              err_o
);
  localparam int PAD_W = 11 - HALF_W;

  logic [HALF_W-1:0] half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q     <= DEF_HALF_MS;
      rdata_o    <= '0;
      rd_valid_o <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      err_o      <= wr_hit_i && !wr_res_i.ok;
      rd_valid_o <= rd_hit_i;
      if (rd_hit_i) rdata_o <= {5'b11111, {PAD_W{1'b0}}, half_q};
      if (rs_hit_i)                      half_q <= rs_res_i.half;
      else if (wr_hit_i && wr_res_i.ok)  half_q <= wr_res_i.half;
    end
  end

  assign half_o = half_q;
endmodule

// File: rtl/ton_delay_timer.sv
module ton_delay_timer
  import ton_pkg::*;
#(
  parameter int MIN_CYC = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              tick_i,
  input  logic [HALF_W-1:0] half_i,
  output logic              ramp_o,
  output logic              min_done_o
);
  localparam int MW = $clog2(MIN_CYC + 1);

  ton_st_e           st_q;
  logic [HALF_W-1:0] tcnt_q;
  logic [MW-1:0]     mcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      tcnt_q <= '0;
      mcnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_WAIT;
          tcnt_q <= half_i;       // value latched at start
          mcnt_q <= MW'(MIN_CYC);
        end
        ST_WAIT: begin
          if (!start_i) st_q <= ST_IDLE;
          else if (tcnt_q == '0 && mcnt_q == '0) st_q <= ST_RAMP;
          else begin
            if (mcnt_q != '0)           mcnt_q <= mcnt_q - MW'(1);
            if (tick_i && tcnt_q != '0) tcnt_q <= tcnt_q - HALF_W'(1);
          end
        end
        ST_RAMP: if (!start_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ramp_o     = (st_q == ST_RAMP);
  assign min_done_o = (mcnt_q == '0);
endmodule

// File: rtl/ton_delay_ctrl.sv
module ton_delay_ctrl
  import ton_pkg::*;
#(
  parameter logic [7:0]        CMD_CODE    = 8'h60,
  parameter logic [HALF_W-1:0] DEF_HALF_MS = 8'd10,
  parameter int                MIN_CYC     = 100
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  cmd_i,
  input  logic        wr_en_i,
  input  logic [15:0] wdata_i,
  input  logic        rd_en_i,
  output logic [15:0] rdata_o,
  output logic        rd_valid_o,
  output logic        err_o,
  input  logic        restore_i,
  input  logic [15:0] restore_data_i,
  input  logic        tick_i,
  input  logic        start_i,
  output logic        ramp_en_o
);
  logic              cmd_hit, wr_hit, rd_hit, wr_ok, min_done;
  lin_res_t          wr_res, rs_res;
  logic [HALF_W-1:0] half_q;

  assign cmd_hit = (cmd_i == CMD_CODE);
  assign wr_hit  = wr_en_i && cmd_hit;
  assign rd_hit  = rd_en_i && cmd_hit;
  assign wr_ok   = wr_res.ok;

  ton_lin11_norm #(.ROUND(1'b0)) u_wr_norm (.word_i(wdata_i),        .res_o(wr_res));
  ton_lin11_norm #(.ROUND(1'b1)) u_rs_norm (.word_i(restore_data_i), .res_o(rs_res));

  ton_delay_reg #(.DEF_HALF_MS(DEF_HALF_MS)) u_reg (
    .clk_i, .rst_ni,
    .wr_hit_i(wr_hit), .wr_res_i(wr_res),
    .rs_hit_i(restore_i), .rs_res_i(rs_res),
    .rd_hit_i(rd_hit),
    .half_o(half_q), .rdata_o, .rd_valid_o, .err_o
  );

  ton_delay_timer #(.MIN_CYC(MIN_CYC)) u_tmr (
    .clk_i, .rst_ni, .start_i, .tick_i,
    .half_i(half_q), .ramp_o(ramp_en_o), .min_done_o(min_done)
  );
endmodule

// File: rtl/ton_delay_chk.sv
module ton_delay_chk #(
  parameter logic [7:0] CMD_CODE = 8'h60
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [7:0]  cmd_i,
  input logic        wr_en_i,
  input logic        rd_en_i,
  input logic        restore_i,
  input logic        start_i,
  input logic        wr_ok,
  input logic        min_done,
  input logic [7:0]  half_q,
  input logic [15:0] rdata_o,
  input logic        rd_valid_o,
  input logic        err_o,
  input logic        ramp_en_o
);
  assert_rd_source_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(rd_en_i && cmd_i == CMD_CODE));
  assert_err_source_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(wr_en_i && cmd_i == CMD_CODE && !restore_i || wr_en_i && cmd_i == CMD_CODE));
  assert_rd_format_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> rdata_o[15:8] == 8'hF8);
  assert_err_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o || $past(wr_en_i && cmd_i == CMD_CODE));
  assert_reject_keeps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && cmd_i == CMD_CODE && !wr_ok && !restore_i |=> $stable(half_q));
  assert_min_wait_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ramp_en_o) |-> $past(min_done));
  assert_abort_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !ramp_en_o);
  assert_ramp_needs_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ramp_en_o) |-> $past(start_i));
endmodule

bind ton_delay_ctrl ton_delay_chk #(.CMD_CODE(CMD_CODE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd_i), .wr_en_i(wr_en_i),
  .rd_en_i(rd_en_i), .restore_i(restore_i), .start_i(start_i),
  .wr_ok(wr_ok), .min_done(min_done), .half_q(half_q),
  .rdata_o(rdata_o), .rd_valid_o(rd_valid_o), .err_o(err_o),
  .ramp_en_o(ramp_en_o)
);

// File: tb/ton_delay_ctrl_tb.sv
module ton_delay_ctrl_tb;
  localparam int CLK_PER = 10;
  localparam int MIN_CYC = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  cmd = 8'h60;
  logic        wr_en = 1'b0, rd_en = 1'b0, restore = 1'b0, tick = 1'b0, start = 1'b0;
  logic [15:0] wdata = '0, rs_data = '0, rdata;
  logic        rd_valid, err, ramp;

  int n_chk = 0, n_bad = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PER/2) clk = ~clk;

  ton_delay_ctrl #(.CMD_CODE(8'h60), .DEF_HALF_MS(8'd10), .MIN_CYC(MIN_CYC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .wr_en_i(wr_en), .wdata_i(wdata),
    .rd_en_i(rd_en), .rdata_o(rdata), .rd_valid_o(rd_valid), .err_o(err),
    .restore_i(restore), .restore_data_i(rs_data), .tick_i(tick),
    .start_i(start), .ramp_en_o(ramp)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read words as they appear
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check("R1 unexpected read", 16'h1, 16'h0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic rd(input string tag, input logic [15:0] exp, input logic [7:0] c = 8'h60);
    @(negedge clk);
    if (c == 8'h60) begin exp_q.push_back(exp); tag_q.push_back(tag); end
    cmd = c; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; cmd = 8'h60;
  endtask

  task automatic wr(input string tag, input logic [15:0] w, input logic exp_err,
                    input logic [7:0] c = 8'h60);
    @(negedge clk);
    cmd = c; wdata = w; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; cmd = 8'h60;
    check(tag, {15'd0, err}, {15'd0, exp_err});
  endtask

  task automatic rst_load(input logic [15:0] w);
    @(negedge clk);
    rs_data = w; restore = 1'b1;
    @(negedge clk);
    restore = 1'b0;
    check("R5 no err on restore", {15'd0, err}, 16'd0);
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PER * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    clocks(3);
    check("R6 ramp reset", {15'd0, ramp}, 16'd0);
    check("R6 err reset", {15'd0, err}, 16'd0);
    check("R6 rd_valid reset", {15'd0, rd_valid}, 16'd0);
    rst_n = 1'b1;
    rd("R6 reset value", 16'hF80A);

    wr("R3 exp -1 m=200", 16'hF8C8, 1'b0);          rd("R3 readback 200", 16'hF8C8);
    wr("R3 exp 0 m=5", 16'h0005, 1'b0);             rd("R3 readback 10", 16'hF80A);
    wr("R3 exp -2 m=6", 16'hF006, 1'b0);            rd("R3 readback 3", 16'hF803);
    wr("R4 off grid exp -2 m=5", 16'hF005, 1'b1);   rd("R4 kept 3", 16'hF803);
    wr("R4 above range m=256", 16'hF900, 1'b1);     rd("R4 kept 3 b", 16'hF803);
    wr("R4 negative", 16'hFFFF, 1'b1);              rd("R4 kept 3 c", 16'hF803);
    wr("R4 exp +1 m=200", 16'h08C8, 1'b1);          rd("R4 kept 3 d", 16'hF803);
    check("R4 err single cycle", {15'd0, err}, 16'd0);
    wr("R3 top of range", 16'hF8FF, 1'b0);          rd("R3 readback 255", 16'hF8FF);
    wr("R1 other code write", 16'hF801, 1'b0, 8'h61); rd("R1 kept 255", 16'hF8FF);
    rd("R1 other code read", 16'h0, 8'h61);
    check("R1 no read strobe", {15'd0, rd_valid}, 16'd0);

    rst_load(16'hF005);  rd("R5 round half up", 16'hF803);
    rst_load(16'h012C);  rd("R5 clamp high", 16'hF8FF);
    rst_load(16'hFFF0);  rd("R5 clamp negative", 16'hF800);
    rst_load(16'hF004);  rd("R5 exact", 16'hF802);

    // zero setting: minimum wait only
    wr("R8 set zero", 16'hF800, 1'b0);
    @(negedge clk); start = 1'b1;
    clocks(MIN_CYC + 1);
    check("R8 low before min", {15'd0, ramp}, 16'd0);
    clocks(1);
    check("R8 high at min", {15'd0, ramp}, 16'd1);
    @(negedge clk); start = 1'b0;
    clocks(1);
    check("R9 ramp drops", {15'd0, ramp}, 16'd0);

    // three ticks; write during countdown must not shorten it
    wr("R10 set 3", 16'hF803, 1'b0);
    @(negedge clk); start = 1'b1;
    clocks(2);
    wr("R10 write zero mid run", 16'hF800, 1'b0);
    clocks(MIN_CYC + 2);
    check("R10 running count kept", {15'd0, ramp}, 16'd0);
    pulse_tick(); pulse_tick();
    check("R7 low after 2 ticks", {15'd0, ramp}, 16'd0);
    pulse_tick();
    check("R7 low on last tick", {15'd0, ramp}, 16'd0);
    clocks(1);
    check("R7 high after last tick", {15'd0, ramp}, 16'd1);
    @(negedge clk); start = 1'b0;
    clocks(2);

    // abort, then restart needs full count
    wr("R9 set 3", 16'hF803, 1'b0);
    @(negedge clk); start = 1'b1;
    clocks(3);
    pulse_tick(); pulse_tick();
    @(negedge clk); start = 1'b0;
    pulse_tick(); pulse_tick();
    clocks(MIN_CYC + 2);
    check("R9 aborted stays low", {15'd0, ramp}, 16'd0);
    @(negedge clk); start = 1'b1;
    clocks(MIN_CYC + 2);
    pulse_tick(); pulse_tick();
    clocks(2);
    check("R9 restart full count", {15'd0, ramp}, 16'd0);
    pulse_tick(); clocks(1);
    check("R9 restart completes", {15'd0, ramp}, 16'd1);
    @(negedge clk); start = 1'b0;
    clocks(3);

    if (exp_q.size() != 0) check("R2 reads missing", 16'(exp_q.size()), 16'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule